// File: doc/BRIEF.md
# Clock Frequency Ratio Monitor

This block measures how fast an unknown clock runs compared with a trusted reference clock. The reference domain defines a fixed measurement window of 2^WIN_BITS reference cycles. A counter in the monitored domain counts monitored edges during that window. When the window closes, the monitored counter is frozen in place. No copy of it is taken. Once the reference side has read the frozen value, the counter is cleared and counting resumes for the next window.

The result is an unsigned fixed-point ratio. It has 16 fractional bits and INT_BITS integer bits, where INT_BITS is a parameter from 1 to 16. A ratio of 1.0 means that both clocks run at the same rate. The frozen count is left-shifted by 16 − WIN_BITS, so any window length up to 16 bits gives the same fraction format.

If the monitored clock stops, the ratio drops to zero rather than keeping the last good reading. The block serves as a status source for a register file or a clock-health supervisor in the reference domain.

Top module: `clk_ratio_monitor`

## Requirements
- R1: `ratio` is an unsigned number with INT_BITS integer bits above 16 fractional bits, equal to f_mon / f_ref (1.0 reads as 0x10000).
- R2: A measurement window lasts 2^WIN_BITS reference cycles. A published ratio is within 4 counts of the true value, where one count weighs 2^(16−WIN_BITS) LSBs.
- R3: At the end of a window the monitored counter holds its value. It does so until the reference side has taken it through a two-flop synchronised request/acknowledge pair. Only then is the counter cleared and restarted.
- R4: The monitored counter saturates instead of wrapping. A clock at or above 2^INT_BITS times the reference reads exactly (2^(INT_BITS+WIN_BITS) − 1) shifted left by 16 − WIN_BITS.
- R5: If the monitored clock stops, `ratio` reads zero within three windows. No earlier nonzero value stays visible.
- R6: When a stopped monitored clock starts again, a correct ratio is published again without a reset.
- R7: After reset `ratio` is zero and stays zero for at least the first 2^WIN_BITS reference cycles, until the first window has been published.
- R8: `ratio` changes at most once per window and holds steady between publications.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock of known frequency |
| ref_rst | input | 1 | Active-high reset, asynchronous assert; also resets the monitored side |
| mon_clk | input | 1 | Clock being measured |
| ratio | output | INT_BITS+16 | Frequency ratio f_mon/f_ref, unsigned, 16 fractional bits |

## Verification
A published ratio appears on `ratio` a few reference cycles after a window closes. That delay covers two synchroniser stages for the stop request, one monitored cycle for the acknowledge, two more stages back, and one output register. Because of this, the first window after a change in clock speed may mix the old and new rates. The bench therefore waits three full windows after every change before it samples, and it compares against the ideal ratio with a tolerance of four counts.

A stopped clock can take up to one running window plus one acknowledge timeout before zero is published, so the bench waits five windows. The reset checks sample at cycle 1 and at cycle 200, both well inside the first window. They are followed by a sample just after that window has been published.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;

    // Reference-side window phase
    typedef enum logic {
        ST_RUN  = 1'b0,   // monitored counter running, window timer counting
        ST_HOLD = 1'b1    // stop requested, waiting for frozen count
    } win_state_e;

    localparam int FRAC_BITS = 16;

endpackage

// File: rtl/clkmon_sync2.sv
`timescale 1ns/1ps
module clkmon_sync2 #(
    parameter int               W       = 1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = d;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sync_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q = sync_q.s2;

endmodule

// File: rtl/clkmon_mon_ctr.sv
`timescale 1ns/1ps
module clkmon_mon_ctr #(
    parameter int CW = 32
) (
    input  logic          mon_clk,
    input  logic          mon_rst,
    input  logic          stop_s,
    output logic [CW-1:0] cnt,
    output logic          ack
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ack;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d = mon_q;
        if (stop_s) begin
            // freeze in place; acknowledge that the value is stable
            mon_d.ack = 1'b1;
        end else if (mon_q.ack) begin
            // release seen: start a fresh window
            mon_d.cnt = '0;
            mon_d.ack = 1'b0;
        end else if (mon_q.cnt != CNT_MAX) begin
            mon_d.cnt = mon_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge mon_clk or posedge mon_rst) begin
        if (mon_rst) begin
            mon_q <= '{cnt: '0, ack: 1'b0};
        end else begin
            mon_q <= mon_d;
        end
    end

    assign cnt = mon_q.cnt;
    assign ack = mon_q.ack;

endmodule

// File: rtl/clkmon_ref_ctrl.sv
`timescale 1ns/1ps
module clkmon_ref_ctrl
    import clkmon_pkg::*;
#(
    parameter int INT_BITS = 16,
    parameter int WIN_BITS = 16
) (
    input  logic                          ref_clk,
    input  logic                          ref_rst,
    input  logic                          ack_s,
    input  logic [INT_BITS+WIN_BITS-1:0]  mon_cnt,
    output logic                          stop_req,
    output logic                          cap_en,
    output logic                          zero_en,
    output logic [INT_BITS+FRAC_BITS-1:0] ratio
);

    localparam int                CW       = INT_BITS + WIN_BITS;
    localparam int                RW       = INT_BITS + FRAC_BITS;
    localparam int                SH       = FRAC_BITS - WIN_BITS;
    localparam logic [WIN_BITS-1:0] WIN_LAST = '1;

    typedef struct packed {
        win_state_e          st;
        logic [WIN_BITS-1:0] win;
        logic                stop;
        logic [RW-1:0]       ratio;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        cap_en    = 1'b0;
        zero_en   = 1'b0;
        ctl_d.win = ctl_q.win + 1'b1;
        case (ctl_q.st)
            ST_RUN: begin
                if (ctl_q.win == WIN_LAST) begin
                    ctl_d.win = '0;
                    if (ack_s) begin
                        // acknowledge never released: monitored side is dead
                        zero_en     = 1'b1;
                        ctl_d.ratio = '0;
                    end else begin
                        ctl_d.stop = 1'b1;
                        ctl_d.st   = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (ack_s) begin
                    cap_en      = 1'b1;
                    ctl_d.ratio = RW'(mon_cnt) << SH;
                    ctl_d.stop  = 1'b0;
                    ctl_d.st    = ST_RUN;
                    ctl_d.win   = '0;
                end else if (ctl_q.win == WIN_LAST) begin
                    // no acknowledge within a whole window
                    zero_en     = 1'b1;
                    ctl_d.ratio = '0;
                    ctl_d.stop  = 1'b0;
                    ctl_d.st    = ST_RUN;
                    ctl_d.win   = '0;
                end
            end
            default: begin
                ctl_d.st = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge ref_clk or posedge ref_rst) begin
        if (ref_rst) begin
            ctl_q <= '{st: ST_RUN, win: '0, stop: 1'b0, ratio: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign stop_req = ctl_q.stop;
    assign ratio    = ctl_q.ratio;

    if (CW + SH != RW) begin : g_bad_width
        initial $display("clkmon_ref_ctrl: inconsistent widths");
    end

endmodule

// File: rtl/clk_ratio_monitor.sv
`timescale 1ns/1ps
module clk_ratio_monitor
    import clkmon_pkg::*;
#(
    parameter int INT_BITS = 16,   // 1..16
    parameter int WIN_BITS = 16    // 1..16, window = 2^WIN_BITS ref cycles
) (
    input  logic                       ref_clk,
    input  logic                       ref_rst,
    input  logic                       mon_clk,
    output logic [INT_BITS+15:0]       ratio
);

    localparam int CW = INT_BITS + WIN_BITS;

    logic          mon_rst;
    logic          stop_req;
    logic          stop_s;
    logic          mon_ack;
    logic          ack_s;
    logic          cap_en;
    logic          zero_en;
    logic [CW-1:0] mon_cnt;

    // reset into the monitored domain: asserted at once, released on mon_clk
    clkmon_sync2 #(.W(1), .RST_VAL(1'b1)) u_mon_rst_sync (
        .clk (mon_clk),
        .rst (ref_rst),
        .d   (1'b0),
        .q   (mon_rst)
    );

    clkmon_sync2 #(.W(1), .RST_VAL(1'b0)) u_stop_sync (
        .clk (mon_clk),
        .rst (mon_rst),
        .d   (stop_req),
        .q   (stop_s)
    );

    clkmon_sync2 #(.W(1), .RST_VAL(1'b0)) u_ack_sync (
        .clk (ref_clk),
        .rst (ref_rst),
        .d   (mon_ack),
        .q   (ack_s)
    );

    clkmon_mon_ctr #(.CW(CW)) u_mon_ctr (
        .mon_clk (mon_clk),
        .mon_rst (mon_rst),
        .stop_s  (stop_s),
        .cnt     (mon_cnt),
        .ack     (mon_ack)
    );

    clkmon_ref_ctrl #(.INT_BITS(INT_BITS), .WIN_BITS(WIN_BITS)) u_ref_ctrl (
        .ref_clk  (ref_clk),
        .ref_rst  (ref_rst),
        .ack_s    (ack_s),
        .mon_cnt  (mon_cnt),
        .stop_req (stop_req),
        .cap_en   (cap_en),
        .zero_en  (zero_en),
        .ratio    (ratio)
    );

endmodule

// File: rtl/clk_ratio_monitor_chk.sv
`timescale 1ns/1ps
module clk_ratio_monitor_chk #(
    parameter int INT_BITS = 16,
    parameter int WIN_BITS = 16
) (
    input logic                         ref_clk,
    input logic                         ref_rst,
    input logic                         mon_clk,
    input logic                         mon_rst,
    input logic                         stop_req,
    input logic                         stop_s,
    input logic                         ack_s,
    input logic                         cap_en,
    input logic                         zero_en,
    input logic [INT_BITS+WIN_BITS-1:0] mon_cnt,
    input logic [INT_BITS+15:0]         ratio
);

    localparam logic [INT_BITS+WIN_BITS-1:0] CNT_MAX = '1;

    // cycles since reset, saturating just past one window
    logic [WIN_BITS:0] since_rst;
    always_ff @(posedge ref_clk or posedge ref_rst) begin
        if (ref_rst) begin
            since_rst <= '0;
        end else if (!since_rst[WIN_BITS]) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R3: request stays up until acknowledged or timed out
    p_stop_held_r3: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (stop_req && !ack_s && !zero_en) |=> stop_req);

    // R3: frozen count does not move while the stop is seen
    p_frozen_r3: assert property (@(posedge mon_clk) disable iff (mon_rst)
        (stop_s && $past(stop_s)) |-> $stable(mon_cnt));

    // R4: no wrap from the top value
    p_no_overflow_r4: assert property (@(posedge mon_clk) disable iff (mon_rst)
        (mon_cnt == CNT_MAX) |=> (mon_cnt == CNT_MAX || mon_cnt == '0));

    // R5: a dead-clock decision publishes zero
    p_zero_pub_r5: assert property (@(posedge ref_clk) disable iff (ref_rst)
        zero_en |=> (ratio == '0));

    // R7: nothing published during the first window
    p_reset_zero_r7: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !since_rst[WIN_BITS] |-> (ratio == '0));

    // R8: output moves only on a publication
    p_stable_r8: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (!cap_en && !zero_en) |=> $stable(ratio));

endmodule

bind clk_ratio_monitor clk_ratio_monitor_chk #(
    .INT_BITS (INT_BITS),
    .WIN_BITS (WIN_BITS)
) u_chk (
    .ref_clk  (ref_clk),
    .ref_rst  (ref_rst),
    .mon_clk  (mon_clk),
    .mon_rst  (mon_rst),
    .stop_req (stop_req),
    .stop_s   (stop_s),
    .ack_s    (ack_s),
    .cap_en   (cap_en),
    .zero_en  (zero_en),
    .mon_cnt  (mon_cnt),
    .ratio    (ratio)
);

// File: tb/clk_ratio_monitor_test.sv
`timescale 1ns/1ps
module clk_ratio_monitor_test;

    localparam int INT_BITS = 2;
    localparam int WIN_BITS = 8;
    localparam int RW       = INT_BITS + 16;
    localparam int WIN      = 1 << WIN_BITS;
    localparam int SETTLE   = 3 * (WIN + 16);
    localparam int TOL      = 4 << (16 - WIN_BITS);
    localparam int SAT_VAL  = ((1 << (INT_BITS + WIN_BITS)) - 1) << (16 - WIN_BITS);

    typedef struct packed {
        logic [31:0]   per_ps;
        logic [31:0]   exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'd10000, 32'h10000},   // 1.0
        '{32'd5000,  32'h20000},   // 2.0
        '{32'd4000,  32'h28000},   // 2.5
        '{32'd25000, 32'h06666},   // 0.4
        '{32'd8000,  32'h14000},   // 1.25
        '{32'd2000,  32'h3FF00}    // 5.0 -> saturated
    };

    logic          ref_clk = 1'b0;
    logic          ref_rst = 1'b1;
    logic          mon_clk = 1'b0;
    logic [RW-1:0] ratio;

    int unsigned mon_half_ps = 5000;
    bit          mon_run     = 1'b1;
    int          n_chk       = 0;
    int          n_bad       = 0;

    clk_ratio_monitor #(.INT_BITS(INT_BITS), .WIN_BITS(WIN_BITS)) uut (
        .ref_clk (ref_clk),
        .ref_rst (ref_rst),
        .mon_clk (mon_clk),
        .ratio   (ratio)
    );

    always #5 ref_clk = ~ref_clk;

    initial begin
        forever begin
            if (mon_run) begin
                #(mon_half_ps / 1000.0);
                mon_clk = ~mon_clk;
            end else begin
                #1;
            end
        end
    end

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic check_near(input string tag, input int act, input int exp, input int tol);
        int diff;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        n_chk++;
        if (diff > tol) begin
            n_bad++;
            $display("FAIL %s: ratio=0x%05h expected 0x%05h (+/-%0d)", tag, act, exp, tol);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #1ms;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int changes;
        logic [RW-1:0] prev;

        wait_ref(5);
        ref_rst = 1'b0;

        // R7: zero out of reset and through the first window
        wait_ref(1);
        check_near("R7 after reset", int'(ratio), 0, 0);
        wait_ref(199);
        check_near("R7 inside first window", int'(ratio), 0, 0);
        wait_ref(100);
        check_near("R7 first publication", int'(ratio), 32'h10000, TOL);

        // R1, R2, R3: vector table of clock periods
        for (int i = 0; i < 6; i++) begin
            mon_half_ps = VECS[i].per_ps / 2;
            wait_ref(SETTLE);
            check_near("R1,R2,R3 vector", int'(ratio), int'(VECS[i].exp), TOL);
        end

        // R4: the last vector exceeds the range, must be exactly saturated
        check_near("R4 saturation", int'(ratio), SAT_VAL, 0);

        // R8: at most one change per window
        mon_half_ps = 5000;
        wait_ref(SETTLE);
        changes = 0;
        prev    = ratio;
        for (int c = 0; c < 2 * WIN + 8; c++) begin
            wait_ref(1);
            if (ratio != prev) changes++;
            prev = ratio;
        end
        check_near("R8 changes in two windows", (changes > 2) ? changes : 0, 0, 0);

        // R5: stopped clock reports zero
        mon_run = 1'b0;
        wait_ref(5 * (WIN + 16));
        check_near("R5 stopped clock", int'(ratio), 0, 0);

        // R6: clock returns at 2.0
        mon_half_ps = 2500;
        mon_run     = 1'b1;
        wait_ref(SETTLE);
        check_near("R6 restarted clock", int'(ratio), 32'h20000, TOL);

        summary();
        $finish;
    end

endmodule